// File: doc/BRIEF.md
# Receive Buffer Lock and Deferred Delivery Controller

This block guards the receive message buffers of a CAN-style controller while the CPU inspects them. When the CPU reads the control/status word of a buffer, that buffer becomes locked from the next clock edge. While it is locked, any hand-off from one of the two serial staging buffers into it is held back rather than lost. The block sees each CPU read as a strobe carrying a buffer index and an access kind. The kind is either a control/status word read or a read of the free-running timer. A timer read drops the lock. A control/status read of another buffer moves the lock there, so at most one buffer is ever locked.

On the receive side, each staging buffer raises a delivery request carrying its target buffer index. In the same cycle the block answers with a grant, which means the buffer storage is written now (`wr_en`, `wr_idx`), or with a defer. A deferred request is kept in a record belonging to that staging buffer, and the record holds the index that was matched when the request arrived. When the lock stops covering that buffer, the block serves the records in the order they arrived, one write per cycle. Records are served before any new request.

The block also shapes the code field returned by a control/status read. The stored code passes through unchanged. The one exception is a read that lands on a buffer being written or moved in that same cycle: then the field carries a fixed BUSY value and the read does not lock.

Top module: `mblk_lock_ctrl`

## Requirements
- R1: After reset no buffer is locked and no record is pending, so the first request to any buffer is granted in the same cycle with no defer.
- R2: A control/status read (`rd_kind`=0) of buffer b with no transfer on b in that cycle locks b from the next clock edge, and from then on a new request aimed at b is answered with defer.
- R3: If buffer b is being written (grant to b) or moved outward (`xout_act` with `xout_idx`=b) in the cycle of a control/status read of b, `rd_code` equals the BUSY value 4'b0001, b is not locked, and any lock held before is released.
- R4: In all other cases `rd_code` equals `stored_code`.
- R5: A control/status read of a different buffer moves the lock, so the old buffer accepts deliveries again on the next edge and the new one defers them.
- R6: A timer read (`rd_kind`=1) releases any lock from the next clock edge.
- R7: A request from a staging buffer with no pending record, aimed at an unlocked buffer and not beaten in arbitration, raises its `dlv_grant` bit, `wr_en` and `wr_idx` in the same cycle.
- R8: A deferred request is kept with its original index. It is written in the first cycle in which the lock no longer covers that index, even if the requester has dropped its request or presents another index by then.
- R9: Pending records are served oldest first, one per cycle, and an eligible record always wins over a new request.
- R10: At most one grant is raised per cycle. Among new requests, the lower staging buffer number wins, and every other new request in that cycle is deferred.
- R11: A request and a control/status read aimed at the same buffer in the same cycle: the request is granted, the read returns BUSY, and the buffer stays unlocked.
- R12: A request from a staging buffer whose record is still pending gets neither grant nor defer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | CPU read strobe |
| rd_kind | input | 1 | 0 = control/status word, 1 = free-running timer |
| rd_idx | input | 4 | Buffer index of the read |
| stored_code | input | 4 | Code field held in storage for `rd_idx` |
| rd_code | output | 4 | Code field returned to the CPU |
| xout_act | input | 1 | An outward move from a buffer is under way this cycle |
| xout_idx | input | 4 | Buffer index of the outward move |
| dlv_req | input | 2 | Delivery request, one bit per staging buffer |
| dlv_idx | input | 8 | Target buffer index, 4 bits per staging buffer (buffer 0 in the low bits) |
| dlv_grant | output | 2 | Delivery performed this cycle, one bit per staging buffer |
| dlv_defer | output | 2 | Request captured as pending this cycle |
| wr_en | output | 1 | Buffer storage write this cycle |
| wr_idx | output | 4 | Buffer written this cycle |

## Verification
The hardest state to reach is two pending records that were captured in different cycles and become eligible in the same cycle. Reaching it takes a lock first. Then one staging buffer requests the locked buffer, and in a later cycle the other one does. After that, a single timer read frees both records, and the grants must come out in arrival order rather than by staging buffer number. A second sequence captures a record while a new request arrives in the very cycle the lock drops, which shows that records win over new requests.

// File: rtl/mblk_pkg.sv
package mblk_pkg;
    localparam int unsigned CODE_W = 4;

    typedef enum logic {
        ACC_CSW = 1'b0,
        ACC_TMR = 1'b1
    } acc_e;
endpackage

// File: rtl/mblk_lock.sv
module mblk_lock
    import mblk_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid,
    input  acc_e             rd_kind,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_busy,
    output logic             lock_v,
    output logic [IDX_W-1:0] lock_idx
);
    typedef struct packed {
        logic             v;
        logic [IDX_W-1:0] idx;
    } lock_t;

    lock_t lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (rd_valid) begin
            if (rd_kind == ACC_TMR) begin
                lock_d.v = 1'b0;
            end else if (rd_busy) begin
                // a read that collides with a transfer releases but never sets
                lock_d.v = 1'b0;
            end else begin
                lock_d.v   = 1'b1;
                lock_d.idx = rd_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign lock_v   = lock_q.v;
    assign lock_idx = lock_q.idx;
endmodule

// File: rtl/mblk_arb.sv
module mblk_arb #(
    parameter int unsigned NUM_SMB = 2,
    parameter int unsigned IDX_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SMB-1:0]       req,
    input  logic [NUM_SMB*IDX_W-1:0] req_idx,
    input  logic                     lock_v,
    input  logic [IDX_W-1:0]         lock_idx,
    output logic [NUM_SMB-1:0]       grant,
    output logic [NUM_SMB-1:0]       defer,
    output logic                     wr_en,
    output logic [IDX_W-1:0]         wr_idx
);
    localparam int unsigned RANK_W = $clog2(NUM_SMB + 1);
    localparam int unsigned SEL_W  = (NUM_SMB > 1) ? $clog2(NUM_SMB) : 1;

    typedef struct packed {
        logic              v;
        logic [IDX_W-1:0]  idx;
        logic [RANK_W-1:0] rank;
    } rec_t;

    rec_t [NUM_SMB-1:0] rec_d, rec_q;

    logic [NUM_SMB-1:0] rec_ok;
    logic [NUM_SMB-1:0] fresh;
    logic [NUM_SMB-1:0] fresh_ok;

    genvar g;
    generate
        for (g = 0; g < NUM_SMB; g++) begin : g_slot
            assign rec_ok[g]   = rec_q[g].v && !(lock_v && rec_q[g].idx == lock_idx);
            assign fresh[g]    = req[g] && !rec_q[g].v;
            assign fresh_ok[g] = fresh[g] &&
                                 !(lock_v && req_idx[g*IDX_W +: IDX_W] == lock_idx);
        end
    endgenerate

    logic              pick_rec;
    logic              pick_new;
    logic [SEL_W-1:0]  rec_sel;
    logic [SEL_W-1:0]  new_sel;
    logic [RANK_W-1:0] best;
    logic [NUM_SMB-1:0] grant_c;
    logic [NUM_SMB-1:0] defer_c;

    // selection: oldest eligible record first, then lowest new request
    always_comb begin
        pick_rec = 1'b0;
        rec_sel  = '0;
        best     = '0;
        for (int i = 0; i < NUM_SMB; i++) begin
            if (rec_ok[i] && (!pick_rec || rec_q[i].rank < best)) begin
                pick_rec = 1'b1;
                rec_sel  = SEL_W'(i);
                best     = rec_q[i].rank;
            end
        end
        pick_new = 1'b0;
        new_sel  = '0;
        for (int i = 0; i < NUM_SMB; i++) begin
            if (!pick_rec && !pick_new && fresh_ok[i]) begin
                pick_new = 1'b1;
                new_sel  = SEL_W'(i);
            end
        end
        grant_c = '0;
        if (pick_rec)      grant_c[rec_sel] = 1'b1;
        else if (pick_new) grant_c[new_sel] = 1'b1;
        defer_c = fresh & ~grant_c;
    end

    logic [RANK_W-1:0] stay;
    logic [RANK_W-1:0] ncap;

    // record update: drop the served one, close rank gaps, append captures
    always_comb begin
        rec_d = rec_q;
        stay  = '0;
        ncap  = '0;
        for (int i = 0; i < NUM_SMB; i++) begin
            if (rec_q[i].v) begin
                if (pick_rec && rec_sel == SEL_W'(i)) begin
                    rec_d[i] = '0;
                end else begin
                    stay = stay + RANK_W'(1);
                    if (pick_rec && rec_q[i].rank > best)
                        rec_d[i].rank = rec_q[i].rank - RANK_W'(1);
                end
            end
        end
        for (int i = 0; i < NUM_SMB; i++) begin
            if (defer_c[i]) begin
                rec_d[i].v    = 1'b1;
                rec_d[i].idx  = req_idx[i*IDX_W +: IDX_W];
                rec_d[i].rank = stay + ncap;
                ncap          = ncap + RANK_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign grant  = grant_c;
    assign defer  = defer_c;
    assign wr_en  = pick_rec || pick_new;
    assign wr_idx = pick_rec ? rec_q[rec_sel].idx : req_idx[new_sel*IDX_W +: IDX_W];
endmodule

// File: rtl/mblk_lock_ctrl.sv
module mblk_lock_ctrl
    import mblk_pkg::*;
#(
    parameter int unsigned       NUM_BUF   = 16,
    parameter int unsigned       NUM_SMB   = 2,
    parameter logic [CODE_W-1:0] BUSY_CODE = 4'b0001,
    localparam int unsigned      IDX_W     = $clog2(NUM_BUF)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_valid,
    input  logic                     rd_kind,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic [CODE_W-1:0]        stored_code,
    output logic [CODE_W-1:0]        rd_code,
    input  logic                     xout_act,
    input  logic [IDX_W-1:0]         xout_idx,
    input  logic [NUM_SMB-1:0]       dlv_req,
    input  logic [NUM_SMB*IDX_W-1:0] dlv_idx,
    output logic [NUM_SMB-1:0]       dlv_grant,
    output logic [NUM_SMB-1:0]       dlv_defer,
    output logic                     wr_en,
    output logic [IDX_W-1:0]         wr_idx
);
    acc_e             kind;
    logic             lock_v;
    logic [IDX_W-1:0] lock_idx;
    logic             rd_busy;
    logic             csw_rd;

    assign kind   = acc_e'(rd_kind);
    assign csw_rd = rd_valid && (kind == ACC_CSW);

    mblk_arb #(
        .NUM_SMB (NUM_SMB),
        .IDX_W   (IDX_W)
    ) i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (dlv_req),
        .req_idx  (dlv_idx),
        .lock_v   (lock_v),
        .lock_idx (lock_idx),
        .grant    (dlv_grant),
        .defer    (dlv_defer),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx)
    );

    // a buffer is busy when it is written or moved out in this very cycle
    assign rd_busy = (wr_en && wr_idx == rd_idx) || (xout_act && xout_idx == rd_idx);

    mblk_lock #(
        .IDX_W (IDX_W)
    ) i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .rd_kind  (kind),
        .rd_idx   (rd_idx),
        .rd_busy  (rd_busy),
        .lock_v   (lock_v),
        .lock_idx (lock_idx)
    );

    assign rd_code = (csw_rd && rd_busy) ? BUSY_CODE : stored_code;
endmodule

// File: rtl/mblk_lock_ctrl_chk.sv
module mblk_lock_ctrl_chk #(
    parameter int unsigned NUM_SMB = 2,
    parameter int unsigned IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_valid,
    input logic               rd_kind,
    input logic [IDX_W-1:0]   rd_idx,
    input logic               rd_busy,
    input logic               lock_v,
    input logic [IDX_W-1:0]   lock_idx,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic [NUM_SMB-1:0] dlv_grant,
    input logic [NUM_SMB-1:0] dlv_defer
);
    a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dlv_grant));

    a_r7_grant_defer_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_grant & dlv_defer) == '0);

    a_r8_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !(lock_v && wr_idx == lock_idx));

    a_r2_lock_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_kind && !rd_busy) |=> (lock_v && lock_idx == $past(rd_idx)));

    a_r3_busy_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_kind && rd_busy) |=> !lock_v);

    a_r6_timer_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_kind) |=> !lock_v);
endmodule

bind mblk_lock_ctrl mblk_lock_ctrl_chk #(
    .NUM_SMB (NUM_SMB),
    .IDX_W   (IDX_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_kind   (rd_kind),
    .rd_idx    (rd_idx),
    .rd_busy   (rd_busy),
    .lock_v    (lock_v),
    .lock_idx  (lock_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .dlv_grant (dlv_grant),
    .dlv_defer (dlv_defer)
);

// File: tb/test_mblk_lock_ctrl.sv
module test_mblk_lock_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_valid, rd_kind, xout_act;
    logic [3:0] rd_idx, stored_code, xout_idx, rd_code, wr_idx;
    logic [1:0] dlv_req, dlv_grant, dlv_defer;
    logic [7:0] dlv_idx;
    logic       wr_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc_n   = 0;
    bit done    = 1'b0;

    typedef struct {
        int stamp;
        int smb;
        int idx;
    } exp_t;
    exp_t sb[$];

    localparam logic [3:0] BUSY = 4'b0001;

    always #5 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    mblk_lock_ctrl i_mblk_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_kind(rd_kind),
        .rd_idx(rd_idx), .stored_code(stored_code), .rd_code(rd_code),
        .xout_act(xout_act), .xout_idx(xout_idx), .dlv_req(dlv_req),
        .dlv_idx(dlv_idx), .dlv_grant(dlv_grant), .dlv_defer(dlv_defer),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic next();
        @(negedge clk);
        rd_valid = 0; rd_kind = 0; rd_idx = 0; stored_code = 0;
        xout_act = 0; xout_idx = 0; dlv_req = 0; dlv_idx = 0;
    endtask

    task automatic req(int s, int idx);
        dlv_req[s] = 1'b1;
        dlv_idx[s*4 +: 4] = 4'(idx);
    endtask

    task automatic csw(int idx, int code);
        rd_valid = 1; rd_kind = 0; rd_idx = 4'(idx); stored_code = 4'(code);
    endtask

    task automatic tmr();
        rd_valid = 1; rd_kind = 1;
    endtask

    task automatic expect_wr(int s, int idx);
        exp_t e;
        e.stamp = cyc_n; e.smb = s; e.idx = idx;
        sb.push_back(e);
    endtask

    task automatic chk_defer(int exp, string tag);
        #1 chk(dlv_defer == 2'(exp), tag, dlv_defer, exp);
    endtask

    // monitor: every write seen on the ports must match the queue head
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (rst_n) begin
                if (wr_en) begin
                    if (sb.size() == 0 || sb[0].stamp != cyc_n) begin
                        n_tests++; n_fail++;
                        $display("FAIL R7 unexpected write actual=%0d expected=none", wr_idx);
                    end else begin
                        chk(wr_idx == 4'(sb[0].idx), "R8 write index", wr_idx, sb[0].idx);
                        chk(dlv_grant == 2'(1 << sb[0].smb), "R9 grant owner",
                            dlv_grant, 1 << sb[0].smb);
                        void'(sb.pop_front());
                    end
                end else if (sb.size() != 0 && sb[0].stamp == cyc_n) begin
                    n_tests++; n_fail++;
                    $display("FAIL R8 missing write actual=none expected=%0d", sb[0].idx);
                    void'(sb.pop_front());
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        next();
        repeat (3) next();
        rst_n = 1'b1;
        next();
        #1 chk(dlv_grant == 0 && wr_en == 0, "R1 idle after reset", wr_en, 0);
        // R1 R7: first request goes straight through
        next(); req(0, 5); expect_wr(0, 5); chk_defer(0, "R1 no defer");
        // R4 R2: read locks buffer 3
        next(); csw(3, 8); #1 chk(rd_code == 4'd8, "R4 stored code", rd_code, 8);
        next(); req(0, 3); chk_defer(1, "R2 locked defers");
        next(); req(1, 7); expect_wr(1, 7); chk_defer(0, "R7 other buffer");
        // R12: smb0 has a record, its new request is ignored; lock still on
        next(); tmr(); req(0, 12); chk_defer(0, "R12 no defer");
        chk(wr_en == 0, "R12 no grant", wr_en, 0);
        // R8: record delivered with original index after release
        next(); expect_wr(0, 3);
        // R9 arrival order across staging buffers
        next(); csw(9, 0);
        next(); req(1, 9); chk_defer(2, "R9 first capture");
        next(); req(0, 9); chk_defer(1, "R9 second capture");
        next(); tmr();
        next(); expect_wr(1, 9);
        next(); expect_wr(0, 9);
        // R10 simultaneous new requests
        next(); req(0, 1); req(1, 2); expect_wr(0, 1); chk_defer(2, "R10 loser deferred");
        next(); expect_wr(1, 2);
        // R11 same-cycle request and read
        next(); req(0, 4); csw(4, 6); expect_wr(0, 4);
        #1 chk(rd_code == BUSY, "R11 busy code", rd_code, BUSY);
        next(); req(1, 4); expect_wr(1, 4); chk_defer(0, "R11 not locked");
        // R3 outward move collision, prior lock released
        next(); csw(2, 5);
        next(); xout_act = 1; xout_idx = 6; csw(6, 7);
        #1 chk(rd_code == BUSY, "R3 busy code", rd_code, BUSY);
        next(); req(0, 6); expect_wr(0, 6); chk_defer(0, "R3 no lock set");
        next(); req(1, 2); expect_wr(1, 2); chk_defer(0, "R3 old lock released");
        // R5 lock moves
        next(); csw(10, 0);
        next(); csw(11, 0);
        next(); req(0, 10); expect_wr(0, 10); chk_defer(0, "R5 old buffer free");
        next(); req(1, 11); chk_defer(2, "R5 new buffer locked");
        next(); tmr();
        next(); expect_wr(1, 11);
        // R9 records beat new requests; R6 release
        next(); csw(13, 0);
        next(); req(0, 13); chk_defer(1, "R9 capture");
        next(); tmr();
        next(); req(1, 14); expect_wr(0, 13); chk_defer(2, "R9 record first");
        next(); expect_wr(1, 14);
        repeat (3) next();
        chk(sb.size() == 0, "R8 all writes seen", sb.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule